// File: doc/BRIEF.md
# Process-Tagged Translation Lookaside Buffer with Page Protection

This block translates 32-bit effective addresses into 32-bit physical addresses for an instruction-fetch port and a load/store port. It holds a small, fully associative set of page mappings. Each lookup is qualified by an address-space bit from the requesting port and by an 8-bit process identifier from the shared context, so mappings owned by different tasks can sit in the buffer together. The effective page number is the upper 20 address bits. The 12-bit page offset is copied straight through, so a cache index lookup can run beside the translation.

Every mapping carries access rights for supervisor and user mode: read, write and execute. It also carries a cache-inhibit flag for I/O pages, a guarded flag that forbids speculative access, and a no-execute flag. A lookup returns the physical address and the page attributes one cycle after it is granted. When no mapping matches, it reports a miss so that software can load a mapping and retry. When the access rights deny the access, it reports a fault.

Software loads mappings through a write port. The write port fills slots in round-robin order. Software removes mappings either all at once or for one process at a time, and mappings tagged as global survive the per-process removal.

Top module: `tlb_xlate`

## Requirements
- R1: When `i_req` and `d_req` are both high in a cycle, the instruction port is granted (`i_gnt`=1, `d_gnt`=0). A lone request is granted in its own cycle.
- R2: A granted request produces `rsp_valid`=1 exactly one clock later, with `rsp_src`=0 for instruction and 1 for data. A cycle with no request gives `rsp_valid`=0 one clock later.
- R3: An entry matches when it is valid, its address-space bit equals the port's, its PID is 0 or equals `ctx_pid`, and its effective page number equals `ea[31:12]`. On a permitted hit, `rsp_pa` = {real page number, `ea[11:0]`}.
- R4: When several entries match, the entry with the lowest index supplies the translation and the attributes.
- R5: When no entry matches, the response has `rsp_miss`=1, `rsp_hit`=0, `rsp_fault`=0, and `rsp_pa`, `rsp_ci` and `rsp_guard` all 0. Exactly one of hit, miss and fault is set in every valid response.
- R6: `wr_perm` is laid out as bit0 supervisor read, bit1 supervisor write, bit2 supervisor execute, bit3 user read, bit4 user write, bit5 user execute. The bit checked is chosen by `ctx_super` and by the access kind: a fetch checks execute, a data access with `d_we`=1 checks write, and any other data access checks read. A denied access on a matching entry gives `rsp_fault`=1 with `rsp_pa`=0.
- R7: An instruction fetch from a page with its no-execute flag set faults even when the execute right is granted. Data accesses to that page are unaffected.
- R8: On a permitted hit, `rsp_ci` and `rsp_guard` carry the matching entry's cache-inhibit and guarded flags.
- R9: Each `wr_en` cycle writes a valid entry into the slot given by a victim pointer. The pointer then advances by one and wraps from 15 to 0. A write takes effect for lookups issued in the following cycle.
- R10: `inv_all` clears every valid bit at the next clock edge. A write in the same cycle is dropped, and the victim pointer does not move.
- R11: `inv_pid_en` clears only the entries that have a non-zero PID equal to `inv_pid`. When it coincides with a write, the newly written entry stays valid.
- R12: After reset, `rsp_valid` is 0, all entries are invalid and the victim pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctx_pid | input | 8 | Current process identifier |
| ctx_super | input | 1 | 1 = supervisor mode |
| i_req | input | 1 | Instruction fetch lookup request |
| i_as | input | 1 | Instruction address-space bit |
| i_ea | input | 32 | Instruction effective address |
| i_gnt | output | 1 | Instruction request granted this cycle |
| d_req | input | 1 | Data lookup request |
| d_as | input | 1 | Data address-space bit |
| d_we | input | 1 | Data access is a store |
| d_ea | input | 32 | Data effective address |
| d_gnt | output | 1 | Data request granted this cycle |
| wr_en | input | 1 | Write a mapping into the victim slot |
| wr_as | input | 1 | Address-space bit of the new mapping |
| wr_pid | input | 8 | PID of the new mapping (0 = global) |
| wr_epn | input | 20 | Effective page number |
| wr_rpn | input | 20 | Real page number |
| wr_perm | input | 6 | Access rights, layout in R6 |
| wr_ci | input | 1 | Cache-inhibit flag |
| wr_guard | input | 1 | Guarded flag |
| wr_nx | input | 1 | No-execute flag |
| inv_all | input | 1 | Invalidate all entries |
| inv_pid_en | input | 1 | Invalidate the entries of one process |
| inv_pid | input | 8 | Process whose entries are removed |
| rsp_valid | output | 1 | Response present |
| rsp_src | output | 1 | 0 = instruction, 1 = data |
| rsp_hit | output | 1 | Permitted translation |
| rsp_miss | output | 1 | No matching entry |
| rsp_fault | output | 1 | Access rights denied |
| rsp_pa | output | 32 | Physical address |
| rsp_ci | output | 1 | Page is cache-inhibited |
| rsp_guard | output | 1 | Page is guarded |

## Verification
A corrupted table entry, a wrong victim pointer or a bad match tag stays hidden until a lookup touches the affected page. It then shows one cycle later as a wrong physical page number, a misplaced miss, or a fault on the response port. Round-robin errors only become visible after enough fills to wrap the pointer, so the bench loads all sixteen slots and then shows that the seventeenth and eighteenth writes displace the oldest mappings. Errors in the removal logic surface on the first lookup after the removal, as a hit that should be a miss or the reverse. The bench therefore probes global entries, foreign-PID entries and removed entries right after each removal.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int EA_W    = 32;
    localparam int OFS_W   = 12;
    localparam int PN_W    = EA_W - OFS_W;
    localparam int PID_W   = 8;
    localparam int PERM_W  = 6;

    localparam int P_SR = 0;
    localparam int P_SW = 1;
    localparam int P_SX = 2;
    localparam int P_UR = 3;
    localparam int P_UW = 4;
    localparam int P_UX = 5;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_t;

    typedef struct packed {
        logic              valid;
        logic              as_id;
        logic [PID_W-1:0]  pid;
        logic [PN_W-1:0]   epn;
        logic [PN_W-1:0]   rpn;
        logic [PERM_W-1:0] perm;
        logic              ci;
        logic              guard;
        logic              nx;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_arb.sv
module tlb_arb
    import tlb_pkg::*;
(
    input  logic            i_req,
    input  logic            i_as,
    input  logic [EA_W-1:0] i_ea,
    input  logic            d_req,
    input  logic            d_as,
    input  logic            d_we,
    input  logic [EA_W-1:0] d_ea,
    output logic            i_gnt,
    output logic            d_gnt,
    output logic            sel_any,
    output logic            sel_src,
    output logic            sel_as,
    output logic [EA_W-1:0] sel_ea,
    output acc_t            sel_kind
);
    always_comb begin
        i_gnt    = i_req;
        d_gnt    = d_req && !i_req;
        sel_any  = i_req || d_req;
        sel_src  = !i_req;
        sel_as   = i_req ? i_as : d_as;
        sel_ea   = i_req ? i_ea : d_ea;
        if (i_req)     sel_kind = ACC_FETCH;
        else if (d_we) sel_kind = ACC_STORE;
        else           sel_kind = ACC_LOAD;
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  tlb_entry_t [NUM_ENTRIES-1:0] tbl,
    input  logic                         q_as,
    input  logic [PID_W-1:0]             q_pid,
    input  logic [PN_W-1:0]              q_epn,
    output logic                         hit,
    output logic [IDX_W-1:0]             hit_idx
);
    logic [NUM_ENTRIES-1:0] line_hit;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        assign line_hit[g] = tbl[g].valid
                          && (tbl[g].as_id == q_as)
                          && ((tbl[g].pid == '0) || (tbl[g].pid == q_pid))
                          && (tbl[g].epn == q_epn);
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int k = NUM_ENTRIES - 1; k >= 0; k--) begin
            if (line_hit[k]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(k);
            end
        end
    end
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
    import tlb_pkg::*;
(
    input  tlb_entry_t ent,
    input  acc_t       kind,
    input  logic       super_mode,
    output logic       allow
);
    always_comb begin
        case (kind)
            ACC_FETCH: allow = (super_mode ? ent.perm[P_SX] : ent.perm[P_UX]) && !ent.nx;
            ACC_STORE: allow = super_mode ? ent.perm[P_SW] : ent.perm[P_UW];
            default:   allow = super_mode ? ent.perm[P_SR] : ent.perm[P_UR];
        endcase
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PID_W-1:0]  ctx_pid,
    input  logic              ctx_super,
    input  logic              i_req,
    input  logic              i_as,
    input  logic [EA_W-1:0]   i_ea,
    output logic              i_gnt,
    input  logic              d_req,
    input  logic              d_as,
    input  logic              d_we,
    input  logic [EA_W-1:0]   d_ea,
    output logic              d_gnt,
    input  logic              wr_en,
    input  logic              wr_as,
    input  logic [PID_W-1:0]  wr_pid,
    input  logic [PN_W-1:0]   wr_epn,
    input  logic [PN_W-1:0]   wr_rpn,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic              wr_ci,
    input  logic              wr_guard,
    input  logic              wr_nx,
    input  logic              inv_all,
    input  logic              inv_pid_en,
    input  logic [PID_W-1:0]  inv_pid,
    output logic              rsp_valid,
    output logic              rsp_src,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_fault,
    output logic [EA_W-1:0]   rsp_pa,
    output logic              rsp_ci,
    output logic              rsp_guard
);
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

    typedef struct packed {
        tlb_entry_t [NUM_ENTRIES-1:0] tbl;
        logic [IDX_W-1:0]             ptr;
        logic                         valid;
        logic                         src;
        logic                         hit;
        logic                         miss;
        logic                         fault;
        logic [EA_W-1:0]              pa;
        logic                         ci;
        logic                         guard;
    } state_t;

    state_t st_d, st_q;

    logic            sel_any, sel_src, sel_as;
    logic [EA_W-1:0] sel_ea;
    acc_t            sel_kind;
    logic            m_hit;
    logic [IDX_W-1:0] m_idx;
    tlb_entry_t      m_ent;
    logic            m_allow;

    tlb_arb u_arb (
        .i_req    (i_req),
        .i_as     (i_as),
        .i_ea     (i_ea),
        .d_req    (d_req),
        .d_as     (d_as),
        .d_we     (d_we),
        .d_ea     (d_ea),
        .i_gnt    (i_gnt),
        .d_gnt    (d_gnt),
        .sel_any  (sel_any),
        .sel_src  (sel_src),
        .sel_as   (sel_as),
        .sel_ea   (sel_ea),
        .sel_kind (sel_kind)
    );

    tlb_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
        .tbl     (st_q.tbl),
        .q_as    (sel_as),
        .q_pid   (ctx_pid),
        .q_epn   (sel_ea[EA_W-1:OFS_W]),
        .hit     (m_hit),
        .hit_idx (m_idx)
    );

    assign m_ent = st_q.tbl[m_idx];

    tlb_perm u_perm (
        .ent        (m_ent),
        .kind       (sel_kind),
        .super_mode (ctx_super),
        .allow      (m_allow)
    );

    always_comb begin
        st_d = st_q;

        // lookup result
        st_d.valid = sel_any;
        st_d.src   = sel_src;
        st_d.hit   = sel_any && m_hit && m_allow;
        st_d.miss  = sel_any && !m_hit;
        st_d.fault = sel_any && m_hit && !m_allow;
        st_d.pa    = '0;
        st_d.ci    = 1'b0;
        st_d.guard = 1'b0;
        if (st_d.hit) begin
            st_d.pa    = {m_ent.rpn, sel_ea[OFS_W-1:0]};
            st_d.ci    = m_ent.ci;
            st_d.guard = m_ent.guard;
        end

        // table maintenance
        if (inv_all) begin
            for (int k = 0; k < NUM_ENTRIES; k++) st_d.tbl[k].valid = 1'b0;
        end else begin
            if (inv_pid_en) begin
                for (int k = 0; k < NUM_ENTRIES; k++) begin
                    if (st_q.tbl[k].pid != '0 && st_q.tbl[k].pid == inv_pid)
                        st_d.tbl[k].valid = 1'b0;
                end
            end
            if (wr_en) begin
                st_d.tbl[st_q.ptr] = '{valid: 1'b1, as_id: wr_as, pid: wr_pid,
                                       epn: wr_epn, rpn: wr_rpn, perm: wr_perm,
                                       ci: wr_ci, guard: wr_guard, nx: wr_nx};
                st_d.ptr = (st_q.ptr == LAST_IDX) ? '0 : st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.valid;
    assign rsp_src   = st_q.src;
    assign rsp_hit   = st_q.hit;
    assign rsp_miss  = st_q.miss;
    assign rsp_fault = st_q.fault;
    assign rsp_pa    = st_q.pa;
    assign rsp_ci    = st_q.ci;
    assign rsp_guard = st_q.guard;
endmodule

// File: rtl/tlb_check.sv
module tlb_check
    import tlb_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            i_req,
    input logic            d_req,
    input logic [EA_W-1:0] i_ea,
    input logic [EA_W-1:0] d_ea,
    input logic            i_gnt,
    input logic            d_gnt,
    input logic            inv_all,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic            rsp_miss,
    input logic            rsp_fault,
    input logic [EA_W-1:0] rsp_pa
);
    assert_ifetch_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (i_req && d_req) |-> (i_gnt && !d_gnt));

    assert_resp_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (i_req || d_req) |=> rsp_valid);

    assert_resp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(i_req || d_req) |=> !rsp_valid);

    assert_offset_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (i_req || d_req) |=>
        (!rsp_hit || rsp_pa[OFS_W-1:0] == $past(i_req ? i_ea[OFS_W-1:0] : d_ea[OFS_W-1:0])));

    assert_single_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_fault}));

    assert_no_pa_on_error_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_miss || rsp_fault) |-> (rsp_pa == '0));

    assert_flush_misses_R10: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all ##1 (i_req || d_req) |=> rsp_miss);
endmodule

bind tlb_xlate tlb_check u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .i_req     (i_req),
    .d_req     (d_req),
    .i_ea      (i_ea),
    .d_ea      (d_ea),
    .i_gnt     (i_gnt),
    .d_gnt     (d_gnt),
    .inv_all   (inv_all),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_fault (rsp_fault),
    .rsp_pa    (rsp_pa)
);

// File: tb/sim_tlb_xlate.sv
`timescale 1ns/1ps
module sim_tlb_xlate;
    import tlb_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [7:0]  ctx_pid = '0;
    logic        ctx_super = 1'b0;
    logic        i_req = 1'b0, i_as = 1'b0;
    logic [31:0] i_ea = '0;
    logic        d_req = 1'b0, d_as = 1'b0, d_we = 1'b0;
    logic [31:0] d_ea = '0;
    logic        i_gnt, d_gnt;
    logic        wr_en = 1'b0, wr_as = 1'b0;
    logic [7:0]  wr_pid = '0;
    logic [19:0] wr_epn = '0, wr_rpn = '0;
    logic [5:0]  wr_perm = '0;
    logic        wr_ci = 1'b0, wr_guard = 1'b0, wr_nx = 1'b0;
    logic        inv_all = 1'b0, inv_pid_en = 1'b0;
    logic [7:0]  inv_pid = '0;
    logic        rsp_valid, rsp_src, rsp_hit, rsp_miss, rsp_fault, rsp_ci, rsp_guard;
    logic [31:0] rsp_pa;

    int checks = 0;
    int errors = 0;

    tlb_xlate u0 (.*);

    typedef struct packed {
        logic [7:0]  pid;
        logic        sup;
        logic        ifetch;
        logic        as_b;
        logic        we;
        logic [31:0] ea;
        logic [36:0] exp;   // {hit, miss, fault, pa, ci, guard}
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{8'd5, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1234_5678, {3'b100, 32'hABCD_E678, 2'b00}}, // R3 R4
        '{8'd5, 1'b0, 1'b0, 1'b0, 1'b1, 32'h1234_5678, {3'b001, 32'h0, 2'b00}},         // R6 user write denied
        '{8'd5, 1'b0, 1'b1, 1'b0, 1'b0, 32'h1234_5678, {3'b100, 32'hABCD_E678, 2'b00}}, // R6 user exec allowed
        '{8'd9, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0001_0ABC, {3'b100, 32'h0002_0ABC, 2'b11}}, // R3 global, R8
        '{8'd9, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0001_0000, {3'b001, 32'h0, 2'b00}},         // R7 no-execute
        '{8'd5, 1'b0, 1'b0, 1'b1, 1'b0, 32'h1234_5000, {3'b001, 32'h0, 2'b00}},         // R6 supervisor-only page
        '{8'd5, 1'b1, 1'b0, 1'b1, 1'b1, 32'h1234_5000, {3'b100, 32'h5555_5000, 2'b00}}, // R3 address space 1, R6
        '{8'd7, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1234_5FFF, {3'b100, 32'h7777_7FFF, 2'b00}}, // R3 PID tag
        '{8'd9, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1234_5000, {3'b010, 32'h0, 2'b00}},         // R5 foreign PID
        '{8'd5, 1'b1, 1'b0, 1'b0, 1'b0, 32'hFFFF_F000, {3'b010, 32'h0, 2'b00}}          // R5 unknown page
    };

    function automatic logic [36:0] got();
        return {rsp_hit, rsp_miss, rsp_fault, rsp_pa, rsp_ci, rsp_guard};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic as_b, input logic [7:0] pid, input logic [19:0] epn,
                      input logic [19:0] rpn, input logic [5:0] perm,
                      input logic ci, input logic g, input logic nx);
        @(negedge clk);
        wr_en = 1'b1; wr_as = as_b; wr_pid = pid; wr_epn = epn; wr_rpn = rpn;
        wr_perm = perm; wr_ci = ci; wr_guard = g; wr_nx = nx;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [7:0] pid, input logic sup, input logic ifetch,
                        input logic as_b, input logic we, input logic [31:0] ea);
        @(negedge clk);
        ctx_pid = pid; ctx_super = sup;
        if (ifetch) begin i_req = 1'b1; i_as = as_b; i_ea = ea; end
        else begin d_req = 1'b1; d_as = as_b; d_we = we; d_ea = ea; end
        @(negedge clk);
        i_req = 1'b0; d_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
        look(8'd5, 1'b1, 1'b0, 1'b0, 1'b0, 32'h1234_5000);
        chk("R12 empty table misses", {27'd0, got()}, {27'd0, 3'b010, 32'h0, 2'b00});
        chk("R2 data response source", {62'd0, rsp_valid, rsp_src}, {62'd0, 2'b11});

        // perm layout {UX,UW,UR,SX,SW,SR}
        wr(1'b0, 8'd5, 20'h12345, 20'hABCDE, 6'b101111, 1'b0, 1'b0, 1'b0); // slot 0
        wr(1'b0, 8'd0, 20'h00010, 20'h00020, 6'b111111, 1'b1, 1'b1, 1'b1); // slot 1 global
        wr(1'b1, 8'd5, 20'h12345, 20'h55555, 6'b000111, 1'b0, 1'b0, 1'b0); // slot 2
        wr(1'b0, 8'd7, 20'h12345, 20'h77777, 6'b111111, 1'b0, 1'b0, 1'b0); // slot 3
        wr(1'b0, 8'd5, 20'h12345, 20'h99999, 6'b111111, 1'b1, 1'b0, 1'b0); // slot 4 duplicate

        foreach (VECS[n]) begin
            look(VECS[n].pid, VECS[n].sup, VECS[n].ifetch, VECS[n].as_b, VECS[n].we, VECS[n].ea);
            chk($sformatf("R3-R8 vector %0d", n), {27'd0, got()}, {27'd0, VECS[n].exp});
        end

        // R1 both ports in one cycle
        @(negedge clk);
        ctx_pid = 8'd5; ctx_super = 1'b0;
        i_req = 1'b1; i_as = 1'b0; i_ea = 32'h1234_5111;
        d_req = 1'b1; d_as = 1'b0; d_we = 1'b0; d_ea = 32'h0001_0222;
        #1;
        chk("R1 grants on collision", {62'd0, i_gnt, d_gnt}, {62'd0, 2'b10});
        @(negedge clk);
        i_req = 1'b0; d_req = 1'b0;
        chk("R1 R2 instruction served", {31'd0, rsp_valid, rsp_src, rsp_pa}, {31'd0, 2'b10, 32'hABCD_E111});
        @(negedge clk);
        chk("R2 idle gives no response", {63'd0, rsp_valid}, 64'd0);

        // R11 per-process removal
        @(negedge clk);
        inv_pid_en = 1'b1; inv_pid = 8'd5;
        @(negedge clk);
        inv_pid_en = 1'b0;
        look(8'd5, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1234_5000);
        chk("R11 removed PID misses", {27'd0, got()}, {27'd0, 3'b010, 32'h0, 2'b00});
        look(8'd7, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1234_5000);
        chk("R11 other PID kept", {27'd0, got()}, {27'd0, 3'b100, 32'h7777_7000, 2'b00});
        look(8'd5, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0001_0000);
        chk("R11 global entry kept", {27'd0, got()}, {27'd0, 3'b100, 32'h0002_0000, 2'b11});

        // R9 fill remaining slots 5..15, then wrap to 0 and 1
        for (int k = 0; k < 11; k++)
            wr(1'b0, 8'd0, 20'h40000 + 20'(k), 20'h30000 + 20'(k), 6'b111111, 1'b0, 1'b0, 1'b0);
        look(8'd1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h4000_A000);
        chk("R9 last slot filled", {27'd0, got()}, {27'd0, 3'b100, 32'h3000_A000, 2'b00});
        wr(1'b0, 8'd0, 20'h50000, 20'h11111, 6'b111111, 1'b0, 1'b0, 1'b0); // slot 0
        wr(1'b0, 8'd0, 20'h60000, 20'h22222, 6'b111111, 1'b0, 1'b0, 1'b0); // slot 1
        look(8'd9, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0001_0000);
        chk("R9 wrapped write replaced slot 1", {27'd0, got()}, {27'd0, 3'b010, 32'h0, 2'b00});
        look(8'd9, 1'b0, 1'b0, 1'b0, 1'b0, 32'h6000_0123);
        chk("R9 new mapping usable", {27'd0, got()}, {27'd0, 3'b100, 32'h2222_2123, 2'b00});

        // R10 flush, with a write in the same cycle dropped
        @(negedge clk);
        inv_all = 1'b1; wr_en = 1'b1; wr_as = 1'b0; wr_pid = 8'd0;
        wr_epn = 20'h70000; wr_rpn = 20'h33333; wr_perm = 6'b111111;
        @(negedge clk);
        inv_all = 1'b0; wr_en = 1'b0;
        look(8'd9, 1'b0, 1'b0, 1'b0, 1'b0, 32'h4000_5000);
        chk("R10 flushed entry misses", {27'd0, got()}, {27'd0, 3'b010, 32'h0, 2'b00});
        look(8'd9, 1'b0, 1'b0, 1'b0, 1'b0, 32'h7000_0000);
        chk("R10 coincident write dropped", {27'd0, got()}, {27'd0, 3'b010, 32'h0, 2'b00});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule